// File: doc/BRIEF.md
# Synchronous Memory-Card Bus Monitor

This block listens passively to a three-wire synchronous memory-card link made of a card reset line, a card clock line and a bidirectional data line. It never drives the link. All three wires are sampled with the fast system clock. From them the block finds four kinds of event: a reset, the start of a command frame, the end of a command frame, and a data bit.

Data bits are packed into bytes with the first bit received in the least significant position. Each finished byte appears for exactly one system cycle on a valid/data output. It carries a tag that says which phase of the protocol it belongs to: reset answer, command, or response data. Reset, frame-start and frame-stop events each produce a one-cycle pulse of their own, so that a logger or trace buffer can mark protocol boundaries.

Top module: `sync_card_monitor`

## Requirements
- R1: A rising edge on the card reset line produces a one-cycle pulse on `reset_evt_o` and discards any partly assembled byte.
- R2: After a reset event, `byte_tag_o` reads 0 (reset answer) and completed bytes carry tag 0.
- R3: A data bit is taken from the data line on every rising edge of the card clock while the card reset line is low. Card clock edges seen while the card reset line is high add no bits.
- R4: A falling edge of the data line while the card clock is high produces a one-cycle pulse on `cmd_start_o`. From then on the tag reads 1 (command).
- R5: A rising edge of the data line while the card clock is high produces a one-cycle pulse on `cmd_stop_o`. From then on the tag reads 2 (response data).
- R6: A frame start or frame stop discards any partly assembled byte, so the next eight bits form a fresh byte.
- R7: Bits are packed least significant first. After the eighth bit, `byte_valid_o` is high for exactly one cycle with the byte on `byte_data_o`, and the bit count starts again from zero.
- R8: Every output result shows up three system clock cycles after the input change that causes it: two synchronizer stages and one output register.
- R9: When a frame start or stop edge and a card clock rising edge reach the detector in the same system cycle, only the frame event is reported and no bit is taken.
- R10: While `rst_ni` is low, all pulses and `byte_valid_o` are 0, `byte_data_o` is 0 and the tag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the card clock |
| rst_ni | input | 1 | Asynchronous active-low system reset, released synchronously |
| card_rst_i | input | 1 | Card reset wire (asynchronous to clk_i) |
| card_clk_i | input | 1 | Card clock wire (asynchronous to clk_i) |
| card_io_i | input | 1 | Card data wire (asynchronous to clk_i) |
| byte_valid_o | output | 1 | One-cycle pulse when a byte completes |
| byte_data_o | output | 8 | Last completed byte, least significant bit received first |
| byte_tag_o | output | 2 | Current phase: 0 reset answer, 1 command, 2 response data |
| reset_evt_o | output | 1 | One-cycle pulse on a card reset event |
| cmd_start_o | output | 1 | One-cycle pulse on a frame start |
| cmd_stop_o | output | 1 | One-cycle pulse on a frame stop |

## Verification
Every result is due exactly three system cycles after the wire change that causes it: two cycles in the synchronizer and one in the output register. The eighth card clock rise is the cause of a byte pulse, and each data-line edge is the cause of its frame pulse. The bench counts rising system edges. For each stimulus it records the edge count at the moment it changes a wire. A monitor sampling on the falling edge records the count at which each pulse appears, and the bench requires the difference to be exactly three. It also counts pulses per scenario, so a missing pulse, an extra pulse or a stretched pulse is reported alongside any wrong byte value or tag.

// File: rtl/cardmon_pkg.sv
package cardmon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TAG_W  = 2;

  typedef enum logic [TAG_W-1:0] {
    TAG_ATR  = 2'd0,
    TAG_CMD  = 2'd1,
    TAG_DATA = 2'd2
  } tag_e;
endpackage

// File: rtl/cardmon_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous wires.
module cardmon_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cardmon_edge.sv
// Finds reset, frame start/stop and data-bit events from synchronized wires.
module cardmon_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_rst_i,
  input  logic s_clk_i,
  input  logic s_io_i,
  output logic evt_reset_o,
  output logic evt_start_o,
  output logic evt_stop_o,
  output logic evt_bit_o,
  output logic bit_val_o
);
  logic prev_rst_q, prev_clk_q, prev_io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rst_q <= 1'b0;
      prev_clk_q <= 1'b0;
      prev_io_q  <= 1'b0;
    end else begin
      prev_rst_q <= s_rst_i;
      prev_clk_q <= s_clk_i;
      prev_io_q  <= s_io_i;
    end
  end

  logic rst_rise, clk_rise, io_fall, io_rise;

  always_comb begin
    rst_rise = s_rst_i & ~prev_rst_q;
    clk_rise = s_clk_i & ~prev_clk_q;
    io_fall  = ~s_io_i & prev_io_q;
    io_rise  = s_io_i & ~prev_io_q;

    // Priority: card reset, then frame events, then data bits.
    evt_reset_o = rst_rise;
    evt_start_o = ~rst_rise & s_clk_i & io_fall;
    evt_stop_o  = ~rst_rise & s_clk_i & io_rise;
    evt_bit_o   = clk_rise & ~s_rst_i & ~evt_start_o & ~evt_stop_o;
    bit_val_o   = s_io_i;
  end
endmodule

// File: rtl/cardmon_assembler.sv
// Packs bits LSB first, tracks the protocol phase and registers all outputs.
module cardmon_assembler
  import cardmon_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_reset_i,
  input  logic              evt_start_i,
  input  logic              evt_stop_i,
  input  logic              evt_bit_i,
  input  logic              bit_val_i,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_data_o,
  output tag_e              tag_o,
  output logic              reset_evt_o,
  output logic              cmd_start_o,
  output logic              cmd_stop_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  tag_e              tag_q,   tag_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q,  data_d;
  logic              rpls_q, spls_q, ppls_q;
  logic              data_en;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    tag_d   = tag_q;
    valid_d = 1'b0;
    data_d  = data_q;
    data_en = 1'b0;
    shifted = {bit_val_i, shift_q[DATA_W-1:1]};

    if (evt_reset_i) begin
      cnt_d   = '0;
      shift_d = '0;
      tag_d   = TAG_ATR;
    end else if (evt_start_i || evt_stop_i) begin
      cnt_d   = '0;
      shift_d = '0;
      tag_d   = evt_start_i ? TAG_CMD : TAG_DATA;
    end else if (evt_bit_i) begin
      shift_d = shifted;
      if (cnt_q == LAST_BIT) begin
        cnt_d   = '0;
        valid_d = 1'b1;
        data_en = 1'b1;
        data_d  = shifted;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
      tag_q   <= TAG_ATR;
      valid_q <= 1'b0;
      rpls_q  <= 1'b0;
      spls_q  <= 1'b0;
      ppls_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      tag_q   <= tag_d;
      valid_q <= valid_d;
      rpls_q  <= evt_reset_i;
      spls_q  <= evt_start_i;
      ppls_q  <= evt_stop_i;
    end
  end

  // Byte holding register with an explicit enable.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign byte_valid_o = valid_q;
  assign byte_data_o  = data_q;
  assign tag_o        = tag_q;
  assign reset_evt_o  = rpls_q;
  assign cmd_start_o  = spls_q;
  assign cmd_stop_o   = ppls_q;
endmodule

// File: rtl/sync_card_monitor.sv
module sync_card_monitor
  import cardmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_rst_i,
  input  logic              card_clk_i,
  input  logic              card_io_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [TAG_W-1:0]  byte_tag_o,
  output logic              reset_evt_o,
  output logic              cmd_start_o,
  output logic              cmd_stop_o
);
  localparam int unsigned NWIRES = 3;

  logic [NWIRES-1:0] wires_sync;
  logic evt_reset, evt_start, evt_stop, evt_bit, bit_val;
  tag_e tag;

  cardmon_sync #(.WIDTH(NWIRES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({card_rst_i, card_clk_i, card_io_i}),
    .sync_o  (wires_sync)
  );

  cardmon_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s_rst_i     (wires_sync[2]),
    .s_clk_i     (wires_sync[1]),
    .s_io_i      (wires_sync[0]),
    .evt_reset_o (evt_reset),
    .evt_start_o (evt_start),
    .evt_stop_o  (evt_stop),
    .evt_bit_o   (evt_bit),
    .bit_val_o   (bit_val)
  );

  cardmon_assembler #(.DATA_W(BYTE_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_reset_i  (evt_reset),
    .evt_start_i  (evt_start),
    .evt_stop_i   (evt_stop),
    .evt_bit_i    (evt_bit),
    .bit_val_i    (bit_val),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .tag_o        (tag),
    .reset_evt_o  (reset_evt_o),
    .cmd_start_o  (cmd_start_o),
    .cmd_stop_o   (cmd_stop_o)
  );

  assign byte_tag_o = tag;
endmodule

// File: rtl/cardmon_checker.sv
module cardmon_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_o,
  input logic [7:0] byte_data_o,
  input logic [1:0] byte_tag_o,
  input logic       reset_evt_o,
  input logic       cmd_start_o,
  input logic       cmd_stop_o
);
  // R7: a card clock rise needs a low phase first, so bytes never come back to back
  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R1: a boundary pulse lasts a single cycle
  assert_reset_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_evt_o |=> !reset_evt_o);

  assert_one_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_evt_o, cmd_start_o, cmd_stop_o, byte_valid_o}));

  assert_reset_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_evt_o |-> byte_tag_o == 2'd0);

  assert_start_tag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> byte_tag_o == 2'd1);

  assert_stop_tag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stop_o |-> byte_tag_o == 2'd2);

  // R7: the byte value only moves together with a valid pulse
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> $stable(byte_data_o));

  // R2 R4 R5: the tag only changes on a boundary event
  assert_tag_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_evt_o || cmd_start_o || cmd_stop_o) |-> $stable(byte_tag_o));

  assert_tag_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_tag_o != 2'd3);
endmodule

bind sync_card_monitor cardmon_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_o (byte_valid_o),
  .byte_data_o  (byte_data_o),
  .byte_tag_o   (byte_tag_o),
  .reset_evt_o  (reset_evt_o),
  .cmd_start_o  (cmd_start_o),
  .cmd_stop_o   (cmd_stop_o)
);

// File: tb/sync_card_monitor_tb.sv
`timescale 1ns/1ps
module sync_card_monitor_tb;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_rst = 1'b0, c_clk = 1'b0, c_io = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [1:0] byte_tag;
  logic       reset_evt, cmd_start, cmd_stop;

  int checks = 0, errors = 0;
  int cyc = 0;
  int n_bytes = 0, n_rst = 0, n_start = 0, n_stop = 0;
  int last_byte_cyc = -1, last_rst_cyc = -1, last_start_cyc = -1, last_stop_cyc = -1;
  logic [7:0] last_data = '0;
  logic [1:0] last_tag = '0;
  int stim = 0;

  always #2 clk = ~clk;

  sync_card_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .card_rst_i(c_rst), .card_clk_i(c_clk), .card_io_i(c_io),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_tag_o(byte_tag),
    .reset_evt_o(reset_evt), .cmd_start_o(cmd_start), .cmd_stop_o(cmd_stop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin n_bytes++; last_byte_cyc = cyc; last_data = byte_data; last_tag = byte_tag; end
      if (reset_evt)  begin n_rst++;   last_rst_cyc = cyc; end
      if (cmd_start)  begin n_start++; last_start_cyc = cyc; end
      if (cmd_stop)   begin n_stop++;  last_stop_cyc = cyc; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output int rise_cyc);
    @(negedge clk); c_clk = 1'b0; c_io = b;
    idle(3);
    c_clk = 1'b1; rise_cyc = cyc;
    idle(3);
  endtask

  task automatic send_byte(input logic [7:0] v, output int last_rise);
    for (int i = 0; i < 8; i++) send_bit(v[i], last_rise);
  endtask

  task automatic do_start();
    @(negedge clk); c_clk = 1'b0; c_io = 1'b1; idle(3);
    c_clk = 1'b1; idle(3);
    c_io = 1'b0; stim = cyc; idle(5);
  endtask

  task automatic do_stop();
    @(negedge clk); c_clk = 1'b0; c_io = 1'b0; idle(3);
    c_clk = 1'b1; idle(3);
    c_io = 1'b1; stim = cyc; idle(5);
  endtask

  task automatic do_reset_event();
    @(negedge clk); c_rst = 1'b1; stim = cyc; idle(6);
    c_rst = 1'b0; idle(3);
  endtask

  task automatic expect_byte(input string req, input int nb0, input int rise,
                             input logic [7:0] v, input logic [1:0] t);
    idle(2);
    chk({req, " byte count"}, n_bytes, nb0 + 1);
    chk({req, " data"}, last_data, v);
    chk({req, " tag"}, last_tag, t);
    chk("R8 byte latency", last_byte_cyc - rise, LAT);
  endtask

  task automatic t_reset_state();
    chk("R10 valid in reset", byte_valid, 0);
    chk("R10 data in reset", byte_data, 0);
    chk("R10 tag in reset", byte_tag, 0);
    chk("R10 pulses in reset", {reset_evt, cmd_start, cmd_stop}, 0);
  endtask

  task automatic t_atr_byte();
    int nr, nb, r;
    nr = n_rst;
    do_reset_event();
    chk("R1 reset pulse count", n_rst, nr + 1);
    chk("R8 reset latency", last_rst_cyc - stim, LAT);
    chk("R2 tag after reset", byte_tag, 0);
    nb = n_bytes;
    send_byte(8'hA5, r);
    expect_byte("R7 R2 atr", nb, r, 8'hA5, 2'd0);
  endtask

  task automatic t_cmd_byte();
    int ns, nb, r;
    ns = n_start;
    do_start();
    chk("R4 start pulse count", n_start, ns + 1);
    chk("R8 start latency", last_start_cyc - stim, LAT);
    chk("R4 tag", byte_tag, 1);
    nb = n_bytes;
    send_byte(8'h3C, r);
    expect_byte("R4 cmd", nb, r, 8'h3C, 2'd1);
  endtask

  task automatic t_partial_discard();
    int nb, r;
    send_bit(1'b1, r); send_bit(1'b0, r); send_bit(1'b1, r);
    do_start();
    nb = n_bytes;
    chk("R6 no byte from partial", n_bytes, nb);
    send_byte(8'h81, r);
    expect_byte("R6 after start", nb, r, 8'h81, 2'd1);
  endtask

  task automatic t_stop_byte();
    int np, nb, r;
    np = n_stop;
    send_bit(1'b1, r); send_bit(1'b1, r);
    do_stop();
    chk("R5 stop pulse count", n_stop, np + 1);
    chk("R8 stop latency", last_stop_cyc - stim, LAT);
    chk("R5 tag", byte_tag, 2);
    nb = n_bytes;
    send_byte(8'h5E, r);
    expect_byte("R5 R6 resp", nb, r, 8'h5E, 2'd2);
  endtask

  task automatic t_reset_discard();
    int nb, r;
    for (int i = 0; i < 5; i++) send_bit(1'b1, r);
    nb = n_bytes;
    do_reset_event();
    chk("R1 no byte from partial", n_bytes, nb);
    send_byte(8'h0F, r);
    expect_byte("R1 after reset", nb, r, 8'h0F, 2'd0);
  endtask

  task automatic t_clk_in_reset();
    int nb, r;
    @(negedge clk); c_rst = 1'b1; idle(5);
    for (int i = 0; i < 4; i++) send_bit(1'b1, r);
    @(negedge clk); c_rst = 1'b0; idle(4);
    nb = n_bytes;
    send_byte(8'hC3, r);
    expect_byte("R3 bits ignored in reset", nb, r, 8'hC3, 2'd0);
  endtask

  task automatic t_simultaneous();
    int ns, nb, r;
    @(negedge clk); c_clk = 1'b0; c_io = 1'b1; idle(4);
    ns = n_start;
    c_clk = 1'b1; c_io = 1'b0; stim = cyc; idle(5);
    chk("R9 start pulse", n_start, ns + 1);
    chk("R9 start latency", last_start_cyc - stim, LAT);
    nb = n_bytes;
    send_byte(8'h77, r);
    expect_byte("R9 no extra bit", nb, r, 8'h77, 2'd1);
  endtask

  task automatic t_sysreset();
    @(negedge clk); rst_n = 1'b0; idle(1);
    t_reset_state();
    @(negedge clk); rst_n = 1'b1; idle(2);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset_state();
        @(negedge clk); rst_n = 1'b1; idle(4);
        t_atr_byte();
        t_cmd_byte();
        t_partial_discard();
        t_stop_byte();
        t_reset_discard();
        t_clk_in_reset();
        t_simultaneous();
        t_sysreset();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule